// File: doc/BRIEF.md
# Serial-Bus Packet Receive Filter

This block sits between the receive side of a serial-bus link and the write port of a general receive FIFO. Received packets arrive one 32-bit quadlet per beat, framed by first, header-end and last markers, together with a CRC-good flag that a separate checker computes. The filter decides from the first quadlet whether the packet concerns this node. It holds the header in a small local stage until the header CRC verdict arrives, and only then passes header, payload and a closing status quadlet to the FIFO.

The status quadlet carries the acknowledge code the link would answer with, or would have answered with for a broadcast. Cycle-start packets never reach the FIFO: their data quadlet goes out on a separate one-cycle strobe to the cycle timer. When cycle marking is enabled, a marker quadlet is placed in the FIFO at each isochronous cycle boundary, always between packets.

Both quadlet streams use valid/ready. A beat moves on a rising edge where valid and ready are both high. A source that raises valid keeps valid and data unchanged until that beat is taken. The filter lowers `in_ready` while it drains the header stage, while it writes a status or marker quadlet, and whenever `out_ready` is low during payload pass-through. It never drops an accepted quadlet because of back-pressure.

Top module: `rxf_packet_filter`

## Requirements
- R1: A packet whose first quadlet is not isochronous and whose destination (bits 31:16) fails the address match is consumed at the input and produces no FIFO write.
- R2: No quadlet of a packet is written before its header-end beat is accepted with a good CRC. With `out_ready` high, the first header quadlet is written on the edge one cycle after that beat.
- R3: When the header CRC flag is low on the header-end beat, the staged header is discarded, and every later quadlet of that packet is consumed without a write.
- R4: An accepted packet is written as its header quadlets in order, then each payload quadlet once and in order, then the status quadlet. Back-pressure on `out_ready` changes no content and no order.
- R5: The status quadlet is {28'h0, code}. The code is 0x1 (complete) for transaction code (bits 7:4) 0x0, 0x1 or 0xA, and 0x2 (pending) for any other. It is 0xD (data error) when the CRC flag is low on the last beat of a packet that has payload.
- R6: A destination whose physical field (bits 5:0) is 0x3F is accepted as broadcast, and gets the same status code a directly addressed packet would.
- R7: A packet with transaction code 0x8 that passes the address match and the header CRC writes nothing to the FIFO. `cyc_valid` is high for one cycle, the cycle after its header-end beat, with `cyc_data` equal to that beat's quadlet.
- R8: A `cycle_end` pulse while `mark_en` is high causes one marker quadlet 32'h0000_00E0 to be written, after any packet in progress. With `mark_en` low, a pulse writes nothing.
- R9: A header longer than HDR_DEPTH quadlets is discarded like a header with a bad CRC.
- R10: Isochronous packets (transaction code 0xA) are accepted whatever their destination field holds.
- R11: Straight after reset, `out_valid` and `cyc_valid` are low and `in_ready` is high.
- R12: The bus field (bits 15:6) matches when it equals the node's bus field or is 0x3FF (the local bus). The physical field matches when it equals the node's or is 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_id | input | 16 | This node's bus (15:6) and physical (5:0) address |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Filter takes the input quadlet |
| in_data | input | 32 | Input quadlet |
| in_first | input | 1 | Beat is the first quadlet of a packet |
| in_hdr_end | input | 1 | Beat is the last header quadlet |
| in_last | input | 1 | Beat is the last quadlet of the packet |
| in_crc_ok | input | 1 | CRC verdict: header CRC on the header-end beat, data CRC on a later last beat |
| out_valid | output | 1 | FIFO write quadlet valid |
| out_ready | input | 1 | FIFO accepts the quadlet |
| out_data | output | 32 | Quadlet to the FIFO |
| cyc_valid | output | 1 | One-cycle strobe carrying cycle-start data |
| cyc_data | output | 32 | Cycle-start data quadlet |
| mark_en | input | 1 | Enables cycle-boundary markers |
| cycle_end | input | 1 | One-cycle pulse at the end of an isochronous cycle |

## Verification
The header-end beat fixes every timing. The first header quadlet is due one edge after it, the rest follow back to back while `out_ready` is high, and the status quadlet comes on the edge after the last payload quadlet. The cycle-start strobe is due exactly one cycle after the header-end beat. The bench drives on the falling edge and samples both ports 4 ns later, just before the rising edge on which a transfer happens. It numbers those samples, so the edge of the first write can be compared exactly with the edge that accepted the header-end beat. Content is checked as an ordered list of transfers, so back-pressure stalls and late markers shift the timing without breaking the comparison.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int QW = 32;
  localparam int NIDW = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_FLUSH, ST_PAY, ST_STAT, ST_DROP
  } rx_state_e;

  localparam logic [3:0] ACK_COMPLETE = 4'h1;
  localparam logic [3:0] ACK_PENDING  = 4'h2;
  localparam logic [3:0] ACK_DATA_ERR = 4'hD;

  localparam logic [3:0] TC_WR_QUAD  = 4'h0;
  localparam logic [3:0] TC_WR_BLOCK = 4'h1;
  localparam logic [3:0] TC_CYC_START = 4'h8;
  localparam logic [3:0] TC_ISO      = 4'hA;

  localparam logic [9:0] BUS_LOCAL = 10'h3FF;
  localparam logic [5:0] PHY_BCAST = 6'h3F;

  localparam logic [QW-1:0] MARK_WORD = 32'h0000_00E0;

  function automatic logic [QW-1:0] status_word(input logic [3:0] code);
    return {{(QW-4){1'b0}}, code};
  endfunction
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  logic [NIDW-1:0] node_id,
  input  logic [QW-1:0]   q0,
  output logic            wanted,
  output logic            is_cyc,
  output logic [3:0]      good_ack
);
  logic [NIDW-1:0] dst;
  logic [3:0]      tcode;
  logic            bus_ok, phy_ok, addr_ok, is_iso;

  always_comb begin
    dst     = q0[QW-1 -: NIDW];
    tcode   = q0[7:4];
    bus_ok  = (dst[15:6] == node_id[15:6]) || (dst[15:6] == BUS_LOCAL);
    phy_ok  = (dst[5:0] == node_id[5:0]) || (dst[5:0] == PHY_BCAST);
    addr_ok = bus_ok && phy_ok;
    is_iso  = (tcode == TC_ISO);
    wanted  = is_iso || addr_ok;
    is_cyc  = !is_iso && addr_ok && (tcode == TC_CYC_START);
    good_ack = (is_iso || tcode == TC_WR_QUAD || tcode == TC_WR_BLOCK)
               ? ACK_COMPLETE : ACK_PENDING;
  end
endmodule

// File: rtl/rxf_hdr_stage.sv
module rxf_hdr_stage #(
  parameter int W     = 32,
  parameter int DEPTH = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          clear,
  input  logic [CW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  first_q,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          ovf
);
  logic [W-1:0] mem [DEPTH];

  assign full    = (count == CW'(DEPTH));
  assign first_q = mem[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      count <= count + CW'(1);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !clear && count == CW'(e)) mem[e] <= din;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx == CW'(e)) rd_data = mem[e];
    end
  end

  // R3: a flush leaves nothing staged
  p_flush_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

  // R2: each staged header quadlet takes one slot
  p_stage_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && !full) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/rxf_packet_filter.sv
module rxf_packet_filter
  import rxf_pkg::*;
#(
  parameter int HDR_DEPTH = 5,
  localparam int CW = $clog2(HDR_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     node_id,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_data,
  input  logic            in_first,
  input  logic            in_hdr_end,
  input  logic            in_last,
  input  logic            in_crc_ok,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_data,
  output logic            cyc_valid,
  output logic [31:0]     cyc_data,
  input  logic            mark_en,
  input  logic            cycle_end
);
  rx_state_e       state;
  logic [3:0]      ack_r;
  logic            last_r;
  logic            mark_pend;
  logic [CW-1:0]   rd_idx;

  logic [QW-1:0]   stg_rd, stg_first;
  logic [CW-1:0]   stg_count;
  logic            stg_full, stg_ovf;
  logic [QW-1:0]   cls_q0;
  logic            cls_wanted, cls_cyc;
  logic [3:0]      cls_ack;

  logic beat, hdr_beat, push, hdr_fail, stg_clear, mark_go;

  assign cls_q0 = (state == ST_IDLE) ? in_data : stg_first;

  rxf_classify u_cls (
    .node_id  (node_id),
    .q0       (cls_q0),
    .wanted   (cls_wanted),
    .is_cyc   (cls_cyc),
    .good_ack (cls_ack)
  );

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    unique case (state)
      ST_IDLE: begin
        in_ready  = !mark_pend;
        out_valid = mark_pend;
        out_data  = MARK_WORD;
      end
      ST_HDR, ST_DROP: in_ready = 1'b1;
      ST_FLUSH: begin
        out_valid = 1'b1;
        out_data  = stg_rd;
      end
      ST_PAY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      ST_STAT: begin
        out_valid = 1'b1;
        out_data  = status_word(ack_r);
      end
      default: ;
    endcase
  end

  assign beat     = in_valid && in_ready;
  assign hdr_beat = beat && ((state == ST_IDLE && in_first) || state == ST_HDR);
  assign push     = hdr_beat && cls_wanted;
  assign hdr_fail = !in_crc_ok || stg_ovf || stg_full;
  assign mark_go  = (state == ST_IDLE) && mark_pend && out_ready;
  assign stg_clear = (hdr_beat && ((in_hdr_end && (hdr_fail || cls_cyc)) ||
                                   (!in_hdr_end && in_last)))
                   || (state == ST_STAT && out_ready);

  rxf_hdr_stage #(.W(QW), .DEPTH(HDR_DEPTH)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .din     (in_data),
    .clear   (stg_clear),
    .rd_idx  (rd_idx),
    .rd_data (stg_rd),
    .first_q (stg_first),
    .count   (stg_count),
    .full    (stg_full),
    .ovf     (stg_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_r     <= ACK_COMPLETE;
      last_r    <= 1'b0;
      rd_idx    <= '0;
      cyc_valid <= 1'b0;
      cyc_data  <= '0;
      mark_pend <= 1'b0;
    end else begin
      cyc_valid <= 1'b0;
      if (cycle_end && mark_en) mark_pend <= 1'b1;
      else if (mark_go)         mark_pend <= 1'b0;
      unique case (state)
        ST_IDLE, ST_HDR: begin
          if (hdr_beat) begin
            if (!cls_wanted) begin
              state <= in_last ? ST_IDLE : ST_DROP;
            end else if (in_hdr_end) begin
              if (hdr_fail) begin
                state <= in_last ? ST_IDLE : ST_DROP;
              end else if (cls_cyc) begin
                cyc_valid <= 1'b1;
                cyc_data  <= in_data;
                state     <= in_last ? ST_IDLE : ST_DROP;
              end else begin
                ack_r  <= cls_ack;
                last_r <= in_last;
                rd_idx <= '0;
                state  <= ST_FLUSH;
              end
            end else if (in_last) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_HDR;
            end
          end
        end
        ST_FLUSH: begin
          if (out_ready) begin
            rd_idx <= rd_idx + CW'(1);
            if (rd_idx + CW'(1) == stg_count) state <= last_r ? ST_STAT : ST_PAY;
          end
        end
        ST_PAY: begin
          if (beat && in_last) begin
            if (!in_crc_ok) ack_r <= ACK_DATA_ERR;
            state <= ST_STAT;
          end
        end
        ST_STAT: if (out_ready) state <= ST_IDLE;
        ST_DROP: if (beat && in_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: an offered FIFO quadlet stays put until taken
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: nothing reaches the FIFO while a header is still arriving
  p_hdr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> !out_valid);

  // R5: status quadlet carries one of the defined codes
  p_ack_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state == ST_STAT) |->
      (out_data[31:4] == '0 &&
       (out_data[3:0] == ACK_COMPLETE || out_data[3:0] == ACK_PENDING ||
        out_data[3:0] == ACK_DATA_ERR)));

  // R7: cycle-start data follows a header beat, never a FIFO write
  p_cyc_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> !$past(out_valid));
endmodule

// File: tb/rxf_packet_filter_tb.sv
module rxf_packet_filter_tb;
  typedef struct packed {
    logic [31:0] q0;
    logic [3:0]  hlen;
    logic [3:0]  plen;
    logic        hcrc;
    logic        dcrc;
    logic        acc;
    logic [3:0]  ack;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0042_1000, 4'd4, 4'd0, 1'b1, 1'b1, 1'b1, 4'h1},
    '{32'h0042_2410, 4'd4, 4'd3, 1'b1, 1'b1, 1'b1, 4'h1},
    '{32'h0042_3810, 4'd4, 4'd3, 1'b1, 1'b0, 1'b1, 4'hD},
    '{32'h0042_0440, 4'd3, 4'd0, 1'b1, 1'b1, 1'b1, 4'h2},
    '{32'h0043_1000, 4'd4, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0},
    '{32'h0042_1410, 4'd4, 4'd2, 1'b0, 1'b1, 1'b0, 4'h0},
    '{32'h007F_0010, 4'd4, 4'd1, 1'b1, 1'b1, 1'b1, 4'h1},
    '{32'hFFC2_0000, 4'd4, 4'd0, 1'b1, 1'b1, 1'b1, 4'h1},
    '{32'h0082_0000, 4'd4, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0},
    '{32'h1234_00A0, 4'd1, 4'd2, 1'b1, 1'b1, 1'b1, 4'h1},
    '{32'h0003_00A0, 4'd1, 4'd2, 1'b1, 1'b0, 1'b1, 4'hD},
    '{32'hFFFF_0050, 4'd4, 4'd0, 1'b1, 1'b1, 1'b1, 4'h2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] node_id = 16'h0042;
  logic        in_valid = 1'b0, in_first = 1'b0, in_hdr_end = 1'b0;
  logic        in_last = 1'b0, in_crc_ok = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, cyc_valid;
  logic [31:0] out_data, cyc_data;
  logic        out_ready = 1'b1;
  logic        mark_en = 1'b0, cycle_end = 1'b0;
  logic        bp_mode = 1'b0;

  int          checks = 0, errors = 0;
  int          cyc_ctr = 0;
  int          rec_n = 0;
  logic [31:0] rec [256];
  int          rec_cyc [256];
  int          cs_cnt = 0;
  logic [31:0] cs_last = '0;
  int          hdr_cyc = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  rxf_packet_filter u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_hdr_end(in_hdr_end), .in_last(in_last),
    .in_crc_ok(in_crc_ok), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cyc_valid(cyc_valid), .cyc_data(cyc_data),
    .mark_en(mark_en), .cycle_end(cycle_end)
  );

  // sample just before each rising edge
  always begin
    @(negedge clk);
    cyc_ctr = cyc_ctr + 1;
    #4;
    if (rst_n && out_valid && out_ready) begin
      rec[rec_n % 256]     = out_data;
      rec_cyc[rec_n % 256] = cyc_ctr;
      rec_n = rec_n + 1;
    end
    if (rst_n && cyc_valid) begin
      cs_cnt  = cs_cnt + 1;
      cs_last = cyc_data;
    end
  end

  always @(negedge clk) out_ready <= bp_mode ? ~out_ready : 1'b1;

  function automatic logic [31:0] qd(input logic [31:0] q0, input int i);
    return q0 + i * 32'h0101_0101;
  endfunction

  function automatic string vreq(input int v);
    case (v)
      1: return "R4";
      4: return "R1";
      5: return "R3";
      6, 11: return "R6";
      7, 8: return "R12";
      9: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] q0, input int hlen, input int plen,
                      input logic hcrc, input logic dcrc);
    int total;
    logic acc;
    total = hlen + plen;
    for (int i = 0; i < total; i++) begin
      in_valid   = 1'b1;
      in_data    = qd(q0, i);
      in_first   = (i == 0);
      in_hdr_end = (i == hlen - 1);
      in_last    = (i == total - 1);
      in_crc_ok  = (i == hlen - 1) ? hcrc : ((i == total - 1) ? dcrc : 1'b1);
      acc = 1'b0;
      while (!acc) begin
        #4;
        acc = in_ready;
        if (acc && i == hlen - 1) hdr_cyc = cyc_ctr;
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_first = 1'b0; in_hdr_end = 1'b0; in_last = 1'b0;
  endtask

  // compare recorded writes from base against an accepted/rejected packet
  task automatic expect_pkt(input int base, input logic [31:0] q0, input int hlen,
                            input int plen, input logic acc, input logic [3:0] ack,
                            input string req);
    int n;
    logic ok;
    logic [31:0] a, e;
    n = acc ? hlen + plen + 1 : 0;
    check(rec_n - base == n, req, "write count", rec_n - base, n);
    ok = 1'b1; a = '0; e = '0;
    for (int i = 0; i < n && i < rec_n - base; i++) begin
      logic [31:0] ex;
      ex = (i == n - 1) ? {28'h0, ack} : qd(q0, i);
      if (ok && rec[(base + i) % 256] !== ex) begin
        ok = 1'b0; a = rec[(base + i) % 256]; e = ex;
      end
    end
    if (n > 0) check(ok, req, "content", a, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    idle(3);
    #4;
    check(!out_valid && !cyc_valid && in_ready, "R11", "reset outputs",
          {29'h0, out_valid, cyc_valid, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      base = rec_n;
      send(VECS[v].q0, int'(VECS[v].hlen), int'(VECS[v].plen), VECS[v].hcrc, VECS[v].dcrc);
      idle(12);
      expect_pkt(base, VECS[v].q0, int'(VECS[v].hlen), int'(VECS[v].plen),
                 VECS[v].acc, VECS[v].ack, vreq(v));
      if (VECS[v].acc && rec_n > base)
        check(rec_cyc[base % 256] == hdr_cyc + 1, "R2", "first write cycle",
              rec_cyc[base % 256], hdr_cyc + 1);
    end

    // R7: cycle-start diverted to the cycle-timer port
    base = rec_n;
    send(32'hFFFF_0080, 4, 0, 1'b1, 1'b1);
    idle(6);
    check(rec_n == base, "R7", "cycle start FIFO writes", rec_n - base, 0);
    check(cs_cnt == 1, "R7", "cycle start strobes", cs_cnt, 1);
    check(cs_last == qd(32'hFFFF_0080, 3), "R7", "cycle start data",
          cs_last, qd(32'hFFFF_0080, 3));

    // R9: header longer than the stage
    base = rec_n;
    send(32'h0042_1410, 6, 2, 1'b1, 1'b1);
    idle(8);
    check(rec_n == base, "R9", "oversized header writes", rec_n - base, 0);

    // R8: marker disabled, then enabled while idle
    base = rec_n;
    mark_en = 1'b0; cycle_end = 1'b1; @(negedge clk); cycle_end = 1'b0;
    idle(5);
    check(rec_n == base, "R8", "marker while disabled", rec_n - base, 0);
    mark_en = 1'b1; cycle_end = 1'b1; @(negedge clk); cycle_end = 1'b0;
    idle(5);
    check(rec_n == base + 1, "R8", "marker count", rec_n - base, 1);
    check(rec[base % 256] == 32'h0000_00E0, "R8", "marker word",
          rec[base % 256], 32'h0000_00E0);

    // R8: marker raised mid-packet lands after the status quadlet
    base = rec_n;
    fork
      send(32'h0042_2410, 4, 3, 1'b1, 1'b1);
      begin
        idle(2);
        cycle_end = 1'b1; @(negedge clk); cycle_end = 1'b0;
      end
    join
    idle(12);
    check(rec_n == base + 9, "R8", "packet plus marker count", rec_n - base, 9);
    check(rec[(base + 7) % 256] == 32'h1, "R8", "status before marker",
          rec[(base + 7) % 256], 32'h1);
    check(rec[(base + 8) % 256] == 32'h0000_00E0, "R8", "marker after packet",
          rec[(base + 8) % 256], 32'h0000_00E0);
    mark_en = 1'b0;

    // R4: same packet under alternating back-pressure
    bp_mode = 1'b1;
    base = rec_n;
    send(32'h0042_2410, 4, 3, 1'b1, 1'b0);
    idle(20);
    expect_pkt(base, 32'h0042_2410, 4, 3, 1'b1, 4'hD, "R4");
    bp_mode = 1'b0;
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end
endmodule